// File: doc/BRIEF.md
# Serial Slave-Answer Packet Receiver

This block listens to one receive line of a half-duplex RS-485 bus and recovers the answer packets that a slave board sends back to the master. It oversamples the line with the system clock, four clock cycles per bit, and rebuilds bytes. Each byte has a low start bit, eight data bits sent least-significant bit first, and two high stop bits. Bytes arrive back to back and form a fixed 28-byte packet.

A packet opens with the delimiter 0x40. The next byte is the master's own address, 0xC0. Then come the slave's address, a firmware identifier and an instruction code. After those are 21 payload bytes, an error-counter byte that is not kept, and a trailing CRC-8 byte. The header fields and the payload are written to parallel output registers. When the packet is complete, one pulse reports it as good or bad. Another master-side block drives the bus enables and sends the requests.

Top module: `serial_answer_rx`

## Requirements
- R1: After reset, `pkt_valid`, `pkt_err`, `slave_id`, `fw_id`, `instr` and `payload` are all zero.
- R2: A byte is a low start bit, eight data bits least-significant first, then two high stop bits. Each bit lasts CPB (4) clock cycles. The line passes through two synchronising flops and is sampled at phase CPB/2 of each bit.
- R3: A low pulse shorter than half a bit does not start a byte. It produces no pulse and does not disturb the packet that follows.
- R4: A packet opens only on a byte equal to 0x40. Any other byte received while hunting for a packet is ignored.
- R5: If packet byte 1 is not 0x40's partner address 0xC0, the packet is dropped with no pulse and no register change. Bytes are then ignored until the line has stayed high for 11 bit periods.
- R6: Packet byte 2 is written to `slave_id`, byte 3 to `fw_id` and byte 4 to `instr`. Payload bytes 5 to 25 are written to `payload`, with byte 5 in bits [7:0] and byte 5+k in bits [8k+7:8k]. Byte 26 is stored nowhere.
- R7: The checksum is a CRC-8 with polynomial 0x07 and initial value 0x00, run MSB-first over bytes 0 to 26. When byte 27 equals this CRC, `pkt_valid` pulses for exactly one cycle.
- R8: When byte 27 does not equal the CRC, `pkt_err` pulses once and `pkt_valid` stays low.
- R9: A stop bit sampled low inside a packet aborts the packet and pulses `pkt_err`. The next packet that opens with 0x40 is then received normally.
- R10: If 64 bit periods (256 cycles) pass inside a packet without a completed byte, the partial packet is dropped and `pkt_err` pulses. Before that limit, no pulse appears.
- R11: `pkt_valid` and `pkt_err` are never high in the same cycle, and each lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx | input | 1 | Serial receive line, idle high |
| pkt_valid | output | 1 | One-cycle pulse: packet complete and CRC correct |
| pkt_err | output | 1 | One-cycle pulse: CRC mismatch, framing error or timeout |
| slave_id | output | 8 | Address of the answering slave |
| fw_id | output | 8 | Firmware identifier of the slave |
| instr | output | 8 | Instruction code of the answer |
| payload | output | 168 | Payload bytes, first byte in the low bits |

## Verification
The in-line assertions check several things on every cycle:
- The two result pulses never overlap and each is a single cycle.
- A completed byte always had a high final stop sample.
- A start that is no longer low at mid-bit puts the byte receiver back to idle.
- The inactivity counter never passes its limit.

Other properties only the directed scenarios can show:
- Field placement and least-significant-first bit order.
- Rejection of a wrong CRC.
- The silent drop of a foreign address, followed by the wait for an idle line.
- Recovery after a framing error.
- The exact point at which the timeout fires.

// File: rtl/serial_answer_rx.sv
module serial_answer_rx #(
  parameter int         CPB         = 4,
  parameter int         PKT_BYTES   = 28,
  parameter logic [7:0] DELIM       = 8'h40,
  parameter logic [7:0] MASTER_ADDR = 8'hC0,
  parameter logic [7:0] CRC_POLY    = 8'h07,
  parameter int         TMO_BITS    = 64,
  parameter int         IDLE_BITS   = 11
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rx,
  output logic                           pkt_valid,
  output logic                           pkt_err,
  output logic [7:0]                     slave_id,
  output logic [7:0]                     fw_id,
  output logic [7:0]                     instr,
  output logic [8*(PKT_BYTES-7)-1:0]     payload
);
  localparam int PW       = 8*(PKT_BYTES-7);
  localparam int PHW      = $clog2(CPB+1);
  localparam int IW       = $clog2(PKT_BYTES);
  localparam int TMO_CYC  = TMO_BITS*CPB;
  localparam int IDLE_CYC = IDLE_BITS*CPB;
  localparam int TW       = $clog2(TMO_CYC+1);
  localparam int DW       = $clog2(IDLE_CYC+1);
  localparam logic [PHW-1:0] PH_LAST = PHW'(CPB-1);
  localparam logic [PHW-1:0] PH_MID  = PHW'(CPB/2);
  localparam logic [IW-1:0]  I_LAST  = IW'(PKT_BYTES-1);
  localparam logic [IW-1:0]  I_PLAST = IW'(PKT_BYTES-3);
  localparam logic [TW-1:0]  T_LAST  = TW'(TMO_CYC-1);
  localparam logic [DW-1:0]  D_LAST  = DW'(IDLE_CYC-1);

  typedef enum logic [1:0] {HUNT, COLLECT, DRAIN} pst_t;

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c ^ d;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ CRC_POLY) : (x << 1);
    return x;
  endfunction

  // byte framing
  logic [1:0]     sync;
  logic           busy, byte_stb, frame_err;
  logic [PHW-1:0] ph;
  logic [3:0]     bit_n;
  logic [7:0]     sh;
  wire            rx_s = sync[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync <= 2'b11; busy <= 1'b0; ph <= '0; bit_n <= '0; sh <= '0;
      byte_stb <= 1'b0; frame_err <= 1'b0;
    end else begin
      sync      <= {sync[0], rx};
      byte_stb  <= 1'b0;
      frame_err <= 1'b0;
      if (!busy) begin
        if (!rx_s) begin busy <= 1'b1; ph <= PHW'(1); bit_n <= '0; end
      end else begin
        ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
        if (ph == PH_LAST) bit_n <= bit_n + 1'b1;
        if (ph == PH_MID) begin
          if (bit_n == 4'd0) begin
            if (rx_s) busy <= 1'b0;
          end else if (bit_n <= 4'd8) sh <= {rx_s, sh[7:1]};
          else if (!rx_s) begin busy <= 1'b0; frame_err <= 1'b1; end
          else if (bit_n == 4'd10) begin busy <= 1'b0; byte_stb <= 1'b1; end
        end
      end
    end
  end

  // packet assembly
  pst_t          st;
  logic [IW-1:0] idx;
  logic [7:0]    crc;
  logic [TW-1:0] tmo;
  logic [DW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= HUNT; idx <= '0; crc <= '0; tmo <= '0; idle_cnt <= '0;
      pkt_valid <= 1'b0; pkt_err <= 1'b0;
      slave_id <= '0; fw_id <= '0; instr <= '0; payload <= '0;
    end else begin
      pkt_valid <= 1'b0;
      pkt_err   <= 1'b0;
      case (st)
        HUNT:
          if (byte_stb && sh == DELIM) begin
            st <= COLLECT; idx <= IW'(1); crc <= crc_step(8'h00, sh); tmo <= '0;
          end
        COLLECT:
          if (frame_err) begin
            pkt_err <= 1'b1; st <= HUNT;
          end else if (byte_stb) begin
            tmo <= '0;
            crc <= crc_step(crc, sh);
            idx <= idx + 1'b1;
            if (idx == IW'(1) && sh != MASTER_ADDR) begin st <= DRAIN; idle_cnt <= '0; end
            if (idx == IW'(2)) slave_id <= sh;
            if (idx == IW'(3)) fw_id    <= sh;
            if (idx == IW'(4)) instr    <= sh;
            if (idx >= IW'(5) && idx <= I_PLAST) payload <= {sh, payload[PW-1:8]};
            if (idx == I_LAST) begin
              st <= HUNT;
              if (sh == crc) pkt_valid <= 1'b1;
              else           pkt_err   <= 1'b1;
            end
          end else if (tmo == T_LAST) begin
            pkt_err <= 1'b1; st <= HUNT;
          end else tmo <= tmo + 1'b1;
        DRAIN:
          if (!rx_s)                  idle_cnt <= '0;
          else if (idle_cnt == D_LAST) st <= HUNT;
          else                         idle_cnt <= idle_cnt + 1'b1;
        default: st <= HUNT;
      endcase
    end
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_valid && pkt_err));                                              // R11
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> !pkt_valid);                                             // R11
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_err |=> !pkt_err);                                                 // R11
  AST_VALID_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> $past(byte_stb));                                        // R7
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> $past(rx_s));                                             // R2
  AST_GLITCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ph == PH_MID && bit_n == 4'd0 && rx_s) |=> !busy);            // R3
  AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tmo <= T_LAST);                                                        // R10
endmodule

// File: tb/test_serial_answer_rx.sv
module test_serial_answer_rx;
  localparam int CPB = 4;
  localparam int NB  = 28;
  localparam int PW  = 8*(NB-7);

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1;
  logic pkt_valid, pkt_err;
  logic [7:0] slave_id, fw_id, instr;
  logic [PW-1:0] payload;

  int n_chk = 0, n_fail = 0, nv = 0, ne = 0;
  logic [7:0] pkt [NB];

  serial_answer_rx i_serial_answer_rx (
    .clk(clk), .rst_n(rst_n), .rx(rx), .pkt_valid(pkt_valid), .pkt_err(pkt_err),
    .slave_id(slave_id), .fw_id(fw_id), .instr(instr), .payload(payload));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (pkt_valid) nv++;
    if (pkt_err)   ne++;
  end

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bitv(input logic b);
    rx = b;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic bad_stop);
    bitv(1'b0);
    for (int i = 0; i < 8; i++) bitv(b[i]);
    bitv(!bad_stop);
    bitv(1'b1);
  endtask

  function automatic logic [7:0] ref_crc();
    logic [7:0] c = 8'h00;
    for (int i = 0; i < NB-1; i++)
      for (int j = 7; j >= 0; j--) begin
        logic fb = c[7] ^ pkt[i][j];
        c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
    return c;
  endfunction

  task automatic build(input logic [7:0] addr, input logic [7:0] slv, input logic [7:0] fw,
                       input logic [7:0] ins, input int seed, input logic [7:0] ecnt);
    pkt[0] = 8'h40; pkt[1] = addr; pkt[2] = slv; pkt[3] = fw; pkt[4] = ins;
    for (int k = 5; k < NB-2; k++) pkt[k] = 8'((k-5)*seed + 3*seed);
    pkt[NB-2] = ecnt;
    pkt[NB-1] = ref_crc();
  endtask

  function automatic logic [PW-1:0] exp_payload();
    logic [PW-1:0] v = '0;
    for (int k = 0; k < NB-7; k++) v[8*k +: 8] = pkt[k+5];
    return v;
  endfunction

  task automatic send_pkt(input int n);
    for (int i = 0; i < n; i++) send_byte(pkt[i], 1'b0);
  endtask

  task automatic t_reset();
    check("R1 valid", PW'(pkt_valid), '0);
    check("R1 err", PW'(pkt_err), '0);
    check("R1 slave_id", PW'(slave_id), '0);
    check("R1 fw_id", PW'(fw_id), '0);
    check("R1 instr", PW'(instr), '0);
    check("R1 payload", payload, '0);
  endtask

  task automatic t_example();
    int v0 = nv, e0 = ne;
    build(8'hC0, 8'h00, 8'h01, 8'h02, 0, 8'h00);
    pkt[6] = 8'hF0; pkt[NB-1] = ref_crc();
    send_pkt(NB); repeat (10) @(negedge clk);
    check("R7 valid count", PW'(nv - v0), PW'(1));
    check("R11 no err", PW'(ne - e0), '0);
    check("R6 slave_id", PW'(slave_id), PW'(8'h00));
    check("R6 fw_id", PW'(fw_id), PW'(8'h01));
    check("R6 instr", PW'(instr), PW'(8'h02));
    check("R2 payload byte6", PW'(payload[15:8]), PW'(8'hF0));
  endtask

  task automatic t_pattern();
    int v0 = nv;
    build(8'hC0, 8'h17, 8'hA3, 8'h5C, 37, 8'h5A);
    send_pkt(NB); repeat (10) @(negedge clk);
    check("R7 valid pattern", PW'(nv - v0), PW'(1));
    check("R6 payload full", payload, exp_payload());
    check("R6 slave_id", PW'(slave_id), PW'(8'h17));
    check("R2 fw_id bit order", PW'(fw_id), PW'(8'hA3));
  endtask

  task automatic t_badcrc();
    int v0 = nv, e0 = ne;
    build(8'hC0, 8'h03, 8'h01, 8'h02, 5, 8'h00);
    pkt[NB-1] = ~pkt[NB-1];
    send_pkt(NB); repeat (10) @(negedge clk);
    check("R8 err count", PW'(ne - e0), PW'(1));
    check("R8 no valid", PW'(nv - v0), '0);
  endtask

  task automatic t_garbage();
    int v0 = nv, e0 = ne;
    send_byte(8'h11, 1'b0); send_byte(8'hC0, 1'b0);
    build(8'hC0, 8'h21, 8'h02, 8'h03, 9, 8'h01);
    send_pkt(NB); repeat (10) @(negedge clk);
    check("R4 valid after junk", PW'(nv - v0), PW'(1));
    check("R4 no err", PW'(ne - e0), '0);
    check("R4 slave_id", PW'(slave_id), PW'(8'h21));
  endtask

  task automatic t_badaddr();
    int v0 = nv, e0 = ne;
    build(8'hC1, 8'h44, 8'h02, 8'h03, 7, 8'h00);
    send_pkt(NB);
    build(8'hC0, 8'h55, 8'h02, 8'h03, 11, 8'h00);
    send_pkt(NB); repeat (10) @(negedge clk);
    check("R5 no pulse", PW'((nv - v0) + (ne - e0)), '0);
    check("R5 slave_id kept", PW'(slave_id), PW'(8'h21));
    repeat (60) @(negedge clk);
    send_pkt(NB); repeat (10) @(negedge clk);
    check("R5 valid after idle", PW'(nv - v0), PW'(1));
    check("R5 slave_id new", PW'(slave_id), PW'(8'h55));
  endtask

  task automatic t_glitch();
    int v0 = nv, e0 = ne;
    rx = 1'b0; @(negedge clk); rx = 1'b1; repeat (20) @(negedge clk);
    check("R3 glitch no pulse", PW'((nv - v0) + (ne - e0)), '0);
    build(8'hC0, 8'h66, 8'h01, 8'h01, 13, 8'h00);
    send_pkt(NB); repeat (10) @(negedge clk);
    check("R3 valid after glitch", PW'(nv - v0), PW'(1));
  endtask

  task automatic t_frame();
    int v0 = nv, e0 = ne;
    build(8'hC0, 8'h77, 8'h01, 8'h01, 3, 8'h00);
    send_pkt(3); send_byte(8'h01, 1'b1); repeat (10) @(negedge clk);
    check("R9 err on framing", PW'(ne - e0), PW'(1));
    repeat (20) @(negedge clk);
    send_pkt(NB); repeat (10) @(negedge clk);
    check("R9 resync valid", PW'(nv - v0), PW'(1));
    check("R9 slave_id", PW'(slave_id), PW'(8'h77));
  endtask

  task automatic t_timeout();
    int e0 = ne;
    build(8'hC0, 8'h88, 8'h01, 8'h01, 2, 8'h00);
    send_pkt(5);
    repeat (200) @(negedge clk);
    check("R10 no early err", PW'(ne - e0), '0);
    repeat (200) @(negedge clk);
    check("R10 timeout err", PW'(ne - e0), PW'(1));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_example();
    t_pattern();
    t_badcrc();
    t_garbage();
    t_badaddr();
    t_glitch();
    t_frame();
    t_timeout();
    $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8*150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
    $finish;
  end
endmodule